// File: doc/BRIEF.md
# Receive-Only Two-Wire Register Writer

This block is a target on a two-wire serial bus that only accepts writes. A fast system clock oversamples the bus clock and data lines. The block recognises bus start, repeated start and stop conditions and compares the first byte of each transfer against its own seven-bit address. That address is a fixed five-bit prefix followed by two strap pins. Every accepted byte is acknowledged by pulling the data line low through an open-drain enable.

After an accepted address, the block reads bytes in groups of three: a pointer byte, then a high data byte, then a low data byte. Each complete group produces a single-cycle write strobe. The strobe carries a channel number, a two-bit register select and a sixteen-bit word. A host can keep sending groups after one address byte, and each group updates another channel. A stop condition ends the session, and any group it cuts short is discarded.

Top module: `i2c_wr_ptr_slave`

## Requirements
- R1: While reset is held and in the first cycle after it, `sda_oe` and `wr_stb` are 0.
- R2: An address byte equal to {1,0,1,0,1, strap[1], strap[0], 0} (MSB first, last bit the direction bit, 0 = write) is acknowledged: the data line is low during the ninth bus clock.
- R3: An address byte with a different value, including one whose direction bit is 1, is not acknowledged. No later byte is acknowledged and no strobe fires until the next start condition.
- R4: After an acknowledged address, the pointer byte and every data byte are acknowledged in their ninth bus clock.
- R5: The pointer byte splits into bits [7:6] = register select and bits [5:0] = channel. The strobe's word is {first data byte, second data byte}. `wr_stb` is high for exactly one system clock, on the third rising system clock edge after the bus clock falls at the end of the second data byte's acknowledge.
- R6: Without a stop, the byte after a completed group is a new pointer. Each further complete group gives one more strobe, and no address byte is resent.
- R7: A stop at any point returns the block to idle. A group that is cut short gives no strobe, and bytes sent after the stop without a new start are not acknowledged.
- R8: A repeated start, with no stop before it, restarts address matching. A correct address then begins a new session.
- R9: `sda_oe` rises only in the cycle after a bus clock fall is detected. It is released by the third system clock edge after the bus clock falls at the end of the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 2 | Low two address bits from strap pins |
| sda_oe | output | 1 | Pull data line low when 1, release when 0 |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_chan | output | 6 | Channel number of the write |
| wr_sel | output | 2 | Register select of the write |
| wr_data | output | 16 | Word written |

## Verification
Every bus input passes through two synchroniser flops and one edge-compare register before the state machine acts on it. The acknowledge drive therefore starts, and the strobe appears, on the third system clock edge after the bus clock edge that causes them. The bench changes its inputs on falling system clock edges and samples on the four falling edges that follow the acknowledge clock's fall. At those edges it expects the strobe pattern 0,0,1,0 for a completing data byte, all zeros for any other byte, and a released data line by the fourth sample. The acknowledge itself is read from the wired data line in the middle of the ninth clock's high phase. By then the drive has settled for a number of cycles.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;
  localparam int CHAN_W = BYTE_W - SEL_W;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_DHI,
    PH_DLO
  } phase_t;

  // address byte accepted only for a write to our own address
  function automatic logic addr_ok(input logic [BYTE_W-1:0] b,
                                   input logic [4:0] prefix,
                                   input logic [1:0] strap);
    return b == {prefix, strap, 1'b0};
  endfunction

  function automatic phase_t next_phase(input phase_t p);
    case (p)
      PH_ADDR: return PH_PTR;
      PH_PTR:  return PH_DHI;
      PH_DHI:  return PH_DLO;
      PH_DLO:  return PH_PTR;
      default: return PH_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '1;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cw_events.sv
module i2cw_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_wr_ptr_slave.sv
module i2c_wr_ptr_slave
  import i2cw_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b10101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_i,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [CHAN_W-1:0] wr_chan,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [WORD_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(BYTE_W + 1);

  // named internal events, visible to the checker
  logic scl_s, sda_s;
  logic scl_rise_ev, scl_fall_ev, start_ev, stop_ev;
  logic byte_accept;

  logic [1:0] synced;
  i2cw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(synced)
  );
  assign scl_s = synced[1];
  assign sda_s = synced[0];

  i2cw_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise_ev), .scl_fall(scl_fall_ev),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  phase_t            phase;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, ptr_q, hi_q;

  assign byte_accept = (phase == PH_ADDR) ? addr_ok(shreg, ADDR_PREFIX, strap_i) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr_q   <= '0;
      hi_q    <= '0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_chan <= '0;
      wr_sel  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_ev) begin
        phase  <= PH_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        phase  <= PH_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise_ev && bitcnt < LAST_BIT) begin
          shreg  <= {shreg[BYTE_W-2:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall_ev && bitcnt == LAST_BIT) begin
          if (byte_accept) begin
            sda_oe <= 1'b1;
            bitcnt <= ACK_CNT;
          end else begin
            phase  <= PH_IDLE;
            bitcnt <= '0;
          end
        end else if (scl_fall_ev && bitcnt == ACK_CNT) begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
          phase  <= next_phase(phase);
          case (phase)
            PH_PTR: ptr_q <= shreg;
            PH_DHI: hi_q  <= shreg;
            PH_DLO: begin
              wr_stb  <= 1'b1;
              wr_chan <= ptr_q[CHAN_W-1:0];
              wr_sel  <= ptr_q[BYTE_W-1:CHAN_W];
              wr_data <= {hi_q, shreg};
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_fall_ev,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_oe,
  input logic wr_stb
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!wr_stb && !sda_oe));

  // R5
  a_r5_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R5
  a_r5_stb_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(scl_fall_ev));

  // R9
  a_r9_oe_rise_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall_ev));

  // R9
  a_r9_oe_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R7
  a_r7_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!sda_oe && !wr_stb));

  // R8
  a_r8_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);
endmodule

bind i2c_wr_ptr_slave i2cw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall_ev(scl_fall_ev),
  .start_ev(start_ev), .stop_ev(stop_ev), .sda_oe(sda_oe), .wr_stb(wr_stb)
);

// File: tb/i2c_wr_ptr_slave_bench.sv
module i2c_wr_ptr_slave_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl, sda_m;
  logic [1:0] strap;
  logic sda_oe, wr_stb;
  logic [5:0] wr_chan;
  logic [1:0] wr_sel;
  logic [15:0] wr_data;
  wire sda_line = sda_m & ~sda_oe;

  i2c_wr_ptr_slave u_i2c_wr_ptr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_chan(wr_chan), .wr_sel(wr_sel),
    .wr_data(wr_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // strobe log
  int nstb = 0;
  logic [23:0] got [0:255];
  always @(negedge clk) if (wr_stb) begin
    if (nstb < 256) got[nstb] = {wr_sel, wr_chan, wr_data};
    nstb++;
  end

  int nexp = 0;
  logic [23:0] expv [0:255];

  function automatic logic [23:0] pack_exp(input logic [7:0] p, input logic [7:0] h,
                                           input logic [7:0] l);
    int chan = p % 64;
    int sel  = p / 64;
    return {sel[1:0], chan[5:0], h, l};
  endfunction

  function automatic logic [7:0] good_addr(input logic [1:0] s);
    return 8'hA8 | (8'(s) << 1);
  endfunction

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; wq(Q); scl = 1; wq(Q); sda_m = 0; wq(Q); scl = 0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(Q); scl = 1; wq(Q); sda_m = 1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit exp_stb,
                           input string req);
    bit acked;
    logic [3:0] stbv;
    logic oe_after;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl = 1; wq(Q); scl = 0; wq(Q);
    end
    sda_m = 1; wq(Q); scl = 1; wq(Q/2);
    acked = !sda_line;
    wq(Q/2); scl = 0;
    for (int k = 0; k < 4; k++) begin
      wq(1);
      stbv[k] = wr_stb;
    end
    oe_after = sda_oe;
    wq(Q-4);
    chk(acked == exp_ack, req, acked, exp_ack);
    chk(stbv == (exp_stb ? 4'b0100 : 4'b0000), "R5 strobe timing", stbv,
        exp_stb ? 4 : 0);
    chk(!oe_after, "R9 release", oe_after, 0);
  endtask

  int seen = 0;
  task automatic compare_log(input string req);
    chk(nstb == nexp, req, nstb, nexp);
    for (int i = seen; i < nexp && i < nstb; i++)
      chk(got[i] == expv[i], "R5 fields", got[i], expv[i]);
    seen = nexp;
  endtask

  // one group: pointer + two data bytes, nb bytes actually sent
  task automatic group(input logic [7:0] p, input logic [7:0] h, input logic [7:0] l,
                       input bit live, input int nb);
    send_byte(p, live, 0, live ? "R4 ptr ack" : "R3 ignored");
    if (nb > 1) send_byte(h, live, 0, live ? "R4 hi ack" : "R3 ignored");
    if (nb > 2) begin
      send_byte(l, live, live, live ? "R6 lo ack" : "R3 ignored");
      if (live) begin expv[nexp] = pack_exp(p, h, l); nexp++; end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; scl = 1; sda_m = 1; strap = 2'b10;
    wq(3);
    chk(!sda_oe && !wr_stb, "R1 in reset", {sda_oe, wr_stb}, 0);
    rst_n = 1; wq(1);
    chk(!sda_oe && !wr_stb, "R1 after reset", {sda_oe, wr_stb}, 0);
    wq(4);

    // directed: extreme pointer/data values, three groups in one session
    bus_start();
    send_byte(good_addr(strap), 1, 0, "R2 addr ack");
    group(8'hFF, 8'hFF, 8'hFF, 1, 3);
    group(8'h00, 8'h00, 8'h00, 1, 3);
    group(8'h81, 8'h12, 8'h34, 1, 3);
    bus_stop();
    compare_log("R6 count");

    // directed: read request refused, later bytes ignored
    bus_start();
    send_byte(good_addr(strap) | 8'h01, 0, 0, "R3 read nack");
    group(8'h05, 8'h55, 8'hAA, 0, 3);
    // repeated start then correct address
    bus_start();
    send_byte(good_addr(strap), 1, 0, "R8 addr after rstart");
    group(8'h42, 8'hBE, 8'hEF, 1, 2);
    bus_stop();
    send_byte(8'h11, 0, 0, "R7 ignored after stop");
    compare_log("R7 partial count");

    // random sessions
    for (int t = 0; t < 28; t++) begin
      int kind, ng;
      bit live, rs;
      logic [7:0] ab;
      kind = $urandom % 10;
      if (kind == 0) ab = good_addr(strap) ^ 8'h80;
      else if (kind == 1) ab = good_addr(strap) | 8'h01;
      else if (kind == 2) ab = good_addr(~strap);
      else ab = good_addr(strap);
      live = (kind >= 3);
      bus_start();
      send_byte(ab, live, 0, live ? "R2 addr ack" : "R3 addr nack");
      ng = 1 + $urandom % 3;
      for (int g = 0; g < ng; g++) begin
        int nb;
        nb = (g == ng-1 && ($urandom % 5 == 0)) ? 1 + $urandom % 2 : 3;
        group(8'($urandom), 8'($urandom), 8'($urandom), live, nb);
      end
      rs = ($urandom % 3 == 0);
      if (!rs) begin
        bus_stop();
        if ($urandom % 4 == 0) send_byte(8'($urandom), 0, 0, "R7 ignored after stop");
        strap = 2'($urandom);
      end
      compare_log(rs ? "R8 count" : "R7 count");
    end
    bus_stop();
    wq(10);
    compare_log("R6 final count");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule